// File: doc/BRIEF.md
# Two-Level Virtual Address Translator

This block turns a 32-bit virtual address into a physical address by walking a two-level page table that lives in ordinary memory. A requester presents the virtual address together with the current table base and table length; the block then performs two dependent word reads over a simple request/response memory port. The first read fetches the entry of the outer table, and the second fetches the entry of the inner table that the outer entry points to. It finishes with a one-cycle completion pulse that carries either the physical address or a fault code.

The virtual address is split into three fields. Bits 31:22 index the outer table, bits 21:12 index the inner table, and bits 11:0 are the byte offset within a 4 KB page. Every table entry is a 32-bit word. Bits 31:12 hold the frame number (or the number of the next table's frame), and bit 0 is the valid flag. The caller switches address spaces by changing only the base value. The data access that follows a translation is the caller's task, so the walker performs two of the three reads that a translated access costs.

Top module: `two_level_walker`

## Requirements
- R1: On success the physical address equals bits 31:12 of the inner entry followed by virtual address bits 11:0 unchanged, and faultCode is 0.
- R2: The first read targets tblBase + 4 × vaddr[31:22], and each read request is a memReq pulse exactly one cycle long.
- R3: After a valid outer entry, the second read targets (outer entry[31:12] × 4096) + 4 × vaddr[21:12], and a successful walk makes exactly two reads.
- R4: An outer entry with bit 0 clear ends the walk with fault set and faultCode 2'b01, after exactly one read.
- R5: An inner entry with bit 0 clear ends the walk with fault set and faultCode 2'b10, after exactly two reads.
- R6: When vaddr[31:22] is greater than or equal to tblLen (11 bits), the walk ends with fault set and faultCode 2'b11, and no memory read is issued.
- R7: Any response latency of one or more cycles after a request is tolerated. A memRvalid pulse that arrives while no read is outstanding is ignored.
- R8: A request is accepted only while reqReady is high, which is only when the walker is idle. reqValid, reqVaddr and tblBase changes while busy have no effect on the walk in progress.
- R9: done is a one-cycle pulse. paddr, fault and faultCode stay stable from done until the next accepted request, and fault is high exactly when faultCode is nonzero.
- R10: A synchronous reset makes the walker idle: reqReady high, and done, fault and memReq low.
- R11: tblBase and tblLen are sampled when a request is accepted, so each walk uses the base and length presented with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Translation request |
| reqVaddr | input | 32 | Virtual address to translate |
| tblBase | input | 32 | Byte address of the outer table |
| tblLen | input | 11 | Number of legal outer indices |
| reqReady | output | 1 | Walker idle and able to accept |
| memReq | output | 1 | One-cycle read request |
| memAddr | output | 32 | Byte address of the entry being read |
| memRvalid | input | 1 | Read response strobe |
| memRdata | input | 32 | Read response word |
| done | output | 1 | Walk finished (one cycle) |
| paddr | output | 32 | Translated physical address |
| fault | output | 1 | Walk ended in a fault |
| faultCode | output | 2 | 01 outer invalid, 10 inner invalid, 11 out of length |

## Verification
The hardest conditions to reach from the ports are traffic that arrives at the wrong moment and misalignment of index and length. One case is a response strobe with no read outstanding. Another is a new request held up, with a different base, while a walk is still in flight. The third is an outer index equal to the length, or one below it. The stimulus sweeps hashed virtual addresses across two bases and latencies of one to five cycles. It injects a lone response strobe while the walker is idle. On some walks it holds reqValid high with altered address and base until the completion pulse. It also sets the length to exactly the outer index, and to the outer index plus one, so that both sides of the bound are hit.

// File: rtl/walk_pkg.sv
package walk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OUTER_REQ,
    ST_OUTER_WAIT,
    ST_INNER_REQ,
    ST_INNER_WAIT,
    ST_DONE
  } walk_state_e;

  localparam logic [1:0] FC_NONE      = 2'b00;
  localparam logic [1:0] FC_OUTER_BAD = 2'b01;
  localparam logic [1:0] FC_INNER_BAD = 2'b10;
  localparam logic [1:0] FC_LENGTH    = 2'b11;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic issueRead;
    logic selInner;
    logic takeOuter;
    logic takeInner;
    logic faultOuter;
    logic faultInner;
    logic faultLen;
  } walk_ctrl_t;

endpackage

// File: rtl/walk_dpath.sv
module walk_dpath
  import walk_pkg::*;
#(
  parameter int OUTER_W = 10,
  parameter int INNER_W = 10,
  parameter int OFF_W   = 12,
  parameter int ENTRY_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  walk_ctrl_t                 ctrl,
  input  logic [OUTER_W+INNER_W+OFF_W-1:0] vaddrIn,
  input  logic [ENTRY_W-1:0]         baseIn,
  input  logic [OUTER_W:0]           lenIn,
  input  logic [ENTRY_W-1:0]         memRdata,
  output logic [ENTRY_W-1:0]         memAddr,
  output logic                       lenBad,
  output logic                       entryValid,
  output logic [ENTRY_W-1:0]         paddr,
  output logic                       fault,
  output logic [1:0]                 faultCode
);
  localparam int VA_W    = OUTER_W + INNER_W + OFF_W;
  localparam int FRAME_W = ENTRY_W - OFF_W;
  localparam int LEN_W   = OUTER_W + 1;
  localparam int IDX_SH  = $clog2(ENTRY_W / 8);

  logic [VA_W-1:0]    vaddrQ;
  logic [ENTRY_W-1:0] baseQ;
  logic [LEN_W-1:0]   lenQ;
  logic [FRAME_W-1:0] nextTblQ;
  logic [ENTRY_W-1:0] paddrQ;
  logic [1:0]         codeQ;

  logic [OUTER_W-1:0] outerIdx;
  logic [INNER_W-1:0] innerIdx;
  logic [OFF_W-1:0]   pageOff;
  logic [ENTRY_W-1:0] outerAddr;
  logic [ENTRY_W-1:0] innerAddr;
  logic               unusedEntryBits;

  assign outerIdx = vaddrQ[VA_W-1 -: OUTER_W];
  assign innerIdx = vaddrQ[OFF_W +: INNER_W];
  assign pageOff  = vaddrQ[OFF_W-1:0];

  assign outerAddr = baseQ + ENTRY_W'({outerIdx, IDX_SH'(0)});
  assign innerAddr = {nextTblQ, OFF_W'(0)} + ENTRY_W'({innerIdx, IDX_SH'(0)});
  assign memAddr   = ctrl.selInner ? innerAddr : outerAddr;

  assign lenBad     = ({1'b0, outerIdx} >= lenQ);
  assign entryValid = memRdata[0];
  assign unusedEntryBits = ^memRdata[OFF_W-1:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      vaddrQ   <= '0;
      baseQ    <= '0;
      lenQ     <= '0;
      nextTblQ <= '0;
      paddrQ   <= '0;
      codeQ    <= FC_NONE;
    end else begin
      if (ctrl.capture) begin
        vaddrQ <= vaddrIn;
        baseQ  <= baseIn;
        lenQ   <= lenIn;
        paddrQ <= '0;
        codeQ  <= FC_NONE;
      end
      if (ctrl.takeOuter) nextTblQ <= memRdata[ENTRY_W-1:OFF_W];
      if (ctrl.takeInner) paddrQ <= {memRdata[ENTRY_W-1:OFF_W], pageOff};
      if (ctrl.faultOuter) codeQ <= FC_OUTER_BAD;
      if (ctrl.faultInner) codeQ <= FC_INNER_BAD;
      if (ctrl.faultLen)   codeQ <= FC_LENGTH;
    end
  end

  assign paddr     = paddrQ;
  assign faultCode = codeQ;
  assign fault     = (codeQ != FC_NONE);

endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       memRvalid,
  input  logic       lenBad,
  input  logic       entryValid,
  output walk_ctrl_t ctrl,
  output logic       reqReady,
  output logic       memReq,
  output logic       done
);
  walk_state_e state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    ctrl      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctrl.capture = 1'b1;
          nextState    = ST_OUTER_REQ;
        end
      end
      ST_OUTER_REQ: begin
        if (lenBad) begin
          ctrl.faultLen = 1'b1;
          nextState     = ST_DONE;
        end else begin
          ctrl.issueRead = 1'b1;
          nextState      = ST_OUTER_WAIT;
        end
      end
      ST_OUTER_WAIT: begin
        if (memRvalid) begin
          if (entryValid) begin
            ctrl.takeOuter = 1'b1;
            nextState      = ST_INNER_REQ;
          end else begin
            ctrl.faultOuter = 1'b1;
            nextState       = ST_DONE;
          end
        end
      end
      ST_INNER_REQ: begin
        ctrl.selInner  = 1'b1;
        ctrl.issueRead = 1'b1;
        nextState      = ST_INNER_WAIT;
      end
      ST_INNER_WAIT: begin
        ctrl.selInner = 1'b1;
        if (memRvalid) begin
          if (entryValid) ctrl.takeInner  = 1'b1;
          else            ctrl.faultInner = 1'b1;
          nextState = ST_DONE;
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign memReq   = ctrl.issueRead;
  assign done     = (state == ST_DONE);

endmodule

// File: rtl/two_level_walker.sv
module two_level_walker
  import walk_pkg::*;
#(
  parameter int OUTER_W = 10,
  parameter int INNER_W = 10,
  parameter int OFF_W   = 12,
  parameter int ENTRY_W = 32,
  localparam int VA_W   = OUTER_W + INNER_W + OFF_W,
  localparam int LEN_W  = OUTER_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  input  logic [VA_W-1:0]    reqVaddr,
  input  logic [ENTRY_W-1:0] tblBase,
  input  logic [LEN_W-1:0]   tblLen,
  output logic               reqReady,
  output logic               memReq,
  output logic [ENTRY_W-1:0] memAddr,
  input  logic               memRvalid,
  input  logic [ENTRY_W-1:0] memRdata,
  output logic               done,
  output logic [ENTRY_W-1:0] paddr,
  output logic               fault,
  output logic [1:0]         faultCode
);
  walk_ctrl_t ctrl;
  logic       lenBad;
  logic       entryValid;

  walk_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .reqValid  (reqValid),
    .memRvalid (memRvalid),
    .lenBad    (lenBad),
    .entryValid(entryValid),
    .ctrl      (ctrl),
    .reqReady  (reqReady),
    .memReq    (memReq),
    .done      (done)
  );

  walk_dpath #(
    .OUTER_W(OUTER_W),
    .INNER_W(INNER_W),
    .OFF_W  (OFF_W),
    .ENTRY_W(ENTRY_W)
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .vaddrIn   (reqVaddr),
    .baseIn    (tblBase),
    .lenIn     (tblLen),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .lenBad    (lenBad),
    .entryValid(entryValid),
    .paddr     (paddr),
    .fault     (fault),
    .faultCode (faultCode)
  );

endmodule

// File: rtl/walk_checker.sv
module walk_checker #(
  parameter int OFF_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             reqValid,
  input logic [OFF_W-1:0] reqOff,
  input logic             reqReady,
  input logic             memReq,
  input logic             done,
  input logic [OFF_W-1:0] paddrLow,
  input logic             fault,
  input logic [1:0]       faultCode
);
  logic [OFF_W-1:0] offCap;
  logic [1:0]       readCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      offCap  <= '0;
      readCnt <= '0;
    end else if (reqValid && reqReady) begin
      offCap  <= reqOff;
      readCnt <= '0;
    end else if (memReq && readCnt != 2'd3) begin
      readCnt <= readCnt + 2'd1;
    end
  end

  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    memReq |=> !memReq);
  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> !reqReady);
  assert_no_read_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
    memReq |-> !reqReady);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_fault_code_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (fault == (faultCode != 2'b00)));
  assert_result_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (!reqReady || !reqValid) && !done && $past(done) |-> $stable(faultCode));
  assert_offset_kept_R1: assert property (@(posedge clk) disable iff (rst)
    (done && !fault) |-> (paddrLow == offCap));
  assert_two_reads_R3: assert property (@(posedge clk) disable iff (rst)
    (done && !fault) |-> (readCnt == 2'd2));
  assert_outer_one_read_R4: assert property (@(posedge clk) disable iff (rst)
    (done && faultCode == 2'b01) |-> (readCnt == 2'd1));
  assert_inner_two_reads_R5: assert property (@(posedge clk) disable iff (rst)
    (done && faultCode == 2'b10) |-> (readCnt == 2'd2));
  assert_len_no_read_R6: assert property (@(posedge clk) disable iff (rst)
    (done && faultCode == 2'b11) |-> (readCnt == 2'd0));
  assert_reset_idle_R10: assert property (@(posedge clk)
    rst |=> (reqReady && !done && !fault && !memReq));

endmodule

bind two_level_walker walk_checker #(.OFF_W(OFF_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reqValid (reqValid),
  .reqOff   (reqVaddr[OFF_W-1:0]),
  .reqReady (reqReady),
  .memReq   (memReq),
  .done     (done),
  .paddrLow (paddr[OFF_W-1:0]),
  .fault    (fault),
  .faultCode(faultCode)
);

// File: tb/sim_two_level_walker.sv
module sim_two_level_walker;
  localparam int PERIOD   = 10;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic [31:0] tblBase = '0;
  logic [10:0] tblLen = '0;
  logic        reqReady, memReq, done, fault;
  logic [31:0] memAddr, paddr;
  logic [1:0]  faultCode;
  logic        respValid = 1'b0;
  logic        strayValid = 1'b0;
  logic        memRvalid;
  logic [31:0] memRdata = '0;

  int checks = 0;
  int failures = 0;
  int reqCount = 0;
  int lat = 0;
  logic [31:0] reqLog [4];
  logic        pend = 1'b0;
  int          cnt = 0;
  logic [31:0] pAddr = '0;

  assign memRvalid = respValid | strayValid;

  always #(PERIOD/2) clk = ~clk;

  two_level_walker u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .tblBase(tblBase), .tblLen(tblLen), .reqReady(reqReady),
    .memReq(memReq), .memAddr(memAddr), .memRvalid(memRvalid),
    .memRdata(memRdata), .done(done), .paddr(paddr), .fault(fault),
    .faultCode(faultCode)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    logic [19:0] f;
    f = a[31:12] ^ {a[11:2], a[11:2]} ^ 20'h13579;
    return {f, 11'd0, (a[4:2] != 3'd5)};
  endfunction

  // Memory model: answers lat cycles after the cycle following a request
  always @(posedge clk) begin
    respValid <= 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        respValid <= 1'b1;
        memRdata  <= memWord(pAddr);
        pend      <= 1'b0;
      end else cnt <= cnt - 1;
    end
    if (memReq) begin
      pend  <= 1'b1;
      cnt   <= lat;
      pAddr <= memAddr;
      reqLog[reqCount % 4] <= memAddr;
      reqCount <= reqCount + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic runWalk(input logic [31:0] va, input logic [31:0] base,
                         input logic [10:0] len, input int l, input bit junk);
    logic [9:0]  oi = va[31:22];
    logic [9:0]  ii = va[21:12];
    logic [31:0] oa, ia, w1, w2, expPa;
    logic [1:0]  expCode;
    int          expReads, start, n;
    string       tag;
    oa = base + {20'd0, oi, 2'b00};
    w1 = memWord(oa);
    ia = {w1[31:12], 12'd0} + {20'd0, ii, 2'b00};
    w2 = memWord(ia);
    expPa = '0;
    if ({1'b0, oi} >= len) begin expCode = 2'b11; expReads = 0; tag = "R6"; end
    else if (!w1[0])       begin expCode = 2'b01; expReads = 1; tag = "R4"; end
    else if (!w2[0])       begin expCode = 2'b10; expReads = 2; tag = "R5"; end
    else begin expCode = 2'b00; expReads = 2; tag = "R1"; expPa = {w2[31:12], va[11:0]}; end

    @(negedge clk);
    start = reqCount;
    reqValid = 1'b1; reqVaddr = va; tblBase = base; tblLen = len; lat = l;
    @(negedge clk);
    if (junk) begin
      reqVaddr = ~va; tblBase = base + 32'h0001_0000; tblLen = 11'd1024;
    end else reqValid = 1'b0;
    n = 0;
    while (!done && n < 60) begin @(negedge clk); n++; end
    chk(n < 60, "R7", "walk completes", n, 60);
    chk(faultCode == expCode, tag, "faultCode", {30'd0, faultCode}, {30'd0, expCode});
    chk(fault == (expCode != 2'b00), "R9", "fault flag", {31'd0, fault}, {31'd0, expCode != 2'b00});
    if (expCode == 2'b00) chk(paddr == expPa, "R1", "paddr", paddr, expPa);
    chk(reqCount - start == expReads, junk ? "R8" : tag, "read count",
        reqCount - start, expReads);
    if (expReads >= 1)
      chk(reqLog[start % 4] == oa, "R2", "outer entry address", reqLog[start % 4], oa);
    if (expReads == 2)
      chk(reqLog[(start + 1) % 4] == ia, "R3", "inner entry address",
          reqLog[(start + 1) % 4], ia);
    reqValid = 1'b0;
    @(negedge clk);
    chk(!done && reqReady, "R9", "done one cycle, idle after", {30'd0, done, reqReady}, 32'd1);
    chk(faultCode == expCode, "R9", "faultCode held", {30'd0, faultCode}, {30'd0, expCode});
    if (expCode == 2'b00) chk(paddr == expPa, "R9", "paddr held", paddr, expPa);
    if (junk) begin
      @(negedge clk);
      chk(reqCount - start == expReads && !memReq, "R8", "no read after busy request",
          reqCount - start, expReads);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] va;
    logic [10:0] len;
    repeat (3) @(negedge clk);
    chk(reqReady && !done && !fault && !memReq, "R10", "reset state",
        {28'd0, reqReady, done, fault, memReq}, 32'h8);
    rst = 1'b0;
    @(negedge clk);
    chk(reqReady && !done && !fault && faultCode == 2'b00, "R10", "idle after reset",
        {29'd0, reqReady, done, fault}, 32'h4);

    // Lone response strobe in idle must be ignored
    strayValid = 1'b1;
    @(negedge clk);
    strayValid = 1'b0;
    @(negedge clk);
    chk(reqReady && !done && reqCount == 0, "R7", "stray response ignored",
        {30'd0, reqReady, done}, 32'h2);

    // Directed: success, then length 0, then bound edges
    runWalk(32'h0040_1ABC, 32'h0010_0000, 11'd1024, 0, 1'b0);
    runWalk(32'h0000_0123, 32'h0010_0000, 11'd0, 2, 1'b0);
    runWalk(32'h0140_2FFF, 32'h0010_0000, 11'd5, 1, 1'b0);
    runWalk(32'h0140_2FFF, 32'h0010_0000, 11'd6, 1, 1'b0);
    // Same address, new base: different address space (R11)
    runWalk(32'h0140_2FFF, 32'h0ABC_0000, 11'd1024, 3, 1'b1);
    // Outer invalid: outer index 5; inner invalid: inner index 5 chain
    runWalk(32'h0140_0000, 32'h0000_0000, 11'd1024, 0, 1'b0);
    runWalk(32'h0080_5000, 32'h0000_0000, 11'd1024, 1, 1'b0);

    for (int i = 0; i < 400; i++) begin
      va = i * 32'h9E37_79B1 + 32'h0000_1234;
      case (i % 4)
        0, 1: len = 11'd1024;
        2:    len = {1'b0, va[31:22]};
        default: len = {1'b0, va[31:22]} + 11'd1;
      endcase
      runWalk(va, (i % 2) ? 32'h0040_0000 : 32'h7FFF_E000, len, i % 5, (i % 9) == 4);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule